// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a possibly hung I2C bus back to idle on request. When a request arrives it lets go of both lines, waits for them to settle, and checks the clock line. If a slave is holding SCL low, nothing can be done and the attempt fails at once. Otherwise the data line is examined. A slave that is stuck partway through a byte is clocked out with single SCL pulses until it releases SDA, up to a fixed limit of pulses.

All timing is counted in ticks of a shared one-microsecond strobe. Each pulse pulls SCL low for a fixed number of ticks. It then releases the line and waits for SCL to read high, which allows for clock stretching up to a bounded limit. After that it waits a settle time before sampling SDA again. The sequencer drives only an SCL pull-down. SDA is never driven, so on SDA it only watches.

The result appears as a one-cycle completion strobe. Alongside it, either a success flag or an error flag is raised, and that flag stays valid until the next request. Byte transfers and a STOP condition after recovery belong to other logic.

Top module: `i2c_bus_unstick`

## Requirements
- R1: While reset is held and directly after it, the SCL pull-down, the done strobe and both result flags are 0.
- R2: A request accepted in idle clears both result flags. The SCL pull-down stays released through the first settle interval of SETTLE_US ticks.
- R3: If SCL reads low at the end of the first settle interval, the run ends with the error flag set and no pulse issued, whatever SDA reads.
- R4: SDA is sampled before each pulse. Reading it high ends the run with the success flag set, and the number of pulses issued equals the number the slave needed.
- R5: No more than MAX_PULSES pulses are issued per run. If SDA is still low after the last one, the run ends with the error flag set.
- R6: Each pulse holds the SCL pull-down active for LOW_US microsecond ticks. In clock cycles that is at least (LOW_US-1) tick periods plus one cycle, and at most LOW_US tick periods plus two cycles.
- R7: After each pulse the sequencer waits for SCL to read high for up to STRETCH_US ticks. Stretching shorter than that is tolerated. If SCL is still low when the limit runs out, the run ends with the error flag set.
- R8: The done strobe is high for exactly one cycle per run. The success and error flags are never both set, and the flag that was raised holds its value until the next accepted request.
- R9: A request raised while a run is in progress has no effect on that run's pulse count or result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle strobe per microsecond |
| start_i | input | 1 | Recovery request |
| scl_i | input | 1 | SCL line level as read from the bus |
| sda_i | input | 1 | SDA line level as read from the bus |
| scl_pull_o | output | 1 | 1 pulls SCL low; 0 releases it |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Bus recovered, held until next request |
| err_o | output | 1 | Recovery failed, held until next request |

## Verification
The assertions check the following on every cycle:
- the two result flags are never both set;
- the completion strobe never lasts longer than one cycle;
- the result flags stay stable between runs;
- SCL is never pulled while a result is shown;
- a run never issues more than the pulse limit.

Other behaviour depends on how a slave responds, so only the bench scenarios can show it. These are the exact pulse count for each possible release point, the tolerance for stretching, the timeout on stretching, the stuck-clock failure and the pulse width in ticks. The bench models a slave that releases SDA after a chosen number of rising clock edges, and it sweeps that number over the full range and beyond.

// File: rtl/unstick_pkg.sv
package unstick_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CHECK,
        ST_LOW,
        ST_RISE,
        ST_SETTLE
    } rec_state_e;
endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                    cnt_d = load_val_i;
        else if (tick_i && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import unstick_pkg::*;
#(
    parameter int MAX_PULSES  = 9,
    parameter int LOW_US      = 2,
    parameter int SETTLE_US   = 2,
    parameter int STRETCH_US  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_pull_o,
    output logic done_o,
    output logic ok_o,
    output logic err_o
);
    localparam int CNT_W   = $clog2(MAX_PULSES + 1);
    localparam int LONGEST = (STRETCH_US > LOW_US)
                           ? ((STRETCH_US > SETTLE_US) ? STRETCH_US : SETTLE_US)
                           : ((LOW_US > SETTLE_US) ? LOW_US : SETTLE_US);
    localparam int TMR_W   = $clog2(LONGEST + 1);

    typedef struct packed {
        rec_state_e       st;
        logic [CNT_W-1:0] pulses;
        logic             pull;
        logic             done;
        logic             ok;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]       lines_s;
    logic             scl_s, sda_s;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;

    unstick_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .sync_o  (lines_s)
    );
    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    unstick_timer #(.W(TMR_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (us_tick),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st     = ST_RELEASE;
                    ctl_d.ok     = 1'b0;
                    ctl_d.err    = 1'b0;
                    ctl_d.pulses = '0;
                    ctl_d.pull   = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(SETTLE_US);
                end
            end
            ST_RELEASE: begin
                if (tmr_exp) begin
                    if (!scl_s) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.err  = 1'b1;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (sda_s) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.ok   = 1'b1;
                    ctl_d.done = 1'b1;
                end else if (ctl_q.pulses == CNT_W'(MAX_PULSES)) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.err  = 1'b1;
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.st     = ST_LOW;
                    ctl_d.pull   = 1'b1;
                    ctl_d.pulses = ctl_q.pulses + 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(LOW_US);
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    ctl_d.st   = ST_RISE;
                    ctl_d.pull = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = TMR_W'(STRETCH_US);
                end
            end
            ST_RISE: begin
                if (scl_s) begin
                    ctl_d.st = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETTLE_US);
                end else if (tmr_exp) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.err  = 1'b1;
                    ctl_d.done = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) ctl_d.st = ST_CHECK;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.pulses <= '0;
            ctl_q.pull   <= 1'b0;
            ctl_q.done   <= 1'b0;
            ctl_q.ok     <= 1'b0;
            ctl_q.err    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_pull_o = ctl_q.pull;
    assign done_o     = ctl_q.done;
    assign ok_o       = ctl_q.ok;
    assign err_o      = ctl_q.err;
endmodule

// File: rtl/i2c_bus_unstick_chk.sv
module i2c_bus_unstick_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_pull_o,
    input logic done_o,
    input logic ok_o,
    input logic err_o
);
    localparam int CW = $clog2(MAX_PULSES + 2);

    logic          pull_prev_q;
    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_prev_q <= 1'b0;
            seen_q      <= '0;
        end else begin
            pull_prev_q <= scl_pull_o;
            if (done_o)                                       seen_q <= '0;
            else if (scl_pull_o && !pull_prev_q && seen_q != '1) seen_q <= seen_q + 1'b1;
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));                                             // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                           // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(start_i)) |-> ($stable(ok_o) && $stable(err_o))); // R8
    AST_NO_PULL_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || err_o) |-> !scl_pull_o);                              // R2
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q <= CW'(MAX_PULSES));                                    // R5
endmodule

bind i2c_bus_unstick i2c_bus_unstick_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .scl_pull_o (scl_pull_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .err_o      (err_o)
);

// File: tb/i2c_bus_unstick_tb_top.sv
module i2c_bus_unstick_tb_top;
    localparam int PERIOD  = 10;
    localparam int TDIV    = 4;
    localparam int MAXP    = 9;
    localparam int LOW     = 2;
    localparam int SETTLE  = 2;
    localparam int STRETCH = 20;
    localparam int NEVER   = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick;
    logic start_i = 1'b0;
    logic scl_i, sda_i;
    logic scl_pull_o, done_o, ok_o, err_o;

    int checks = 0;
    int fails  = 0;

    // slave model configuration
    int k_rel    = NEVER;
    bit stuck    = 1'b0;
    int hold_len = 0;
    bit clr      = 1'b0;

    int  tick_cnt = 0;
    int  rise_cnt, pulse_cnt, done_cnt, hold_cnt, width, min_w, max_w;
    bit  hold_used, scl_prev, pull_prev;

    always #(PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) tick_cnt <= (tick_cnt == TDIV-1) ? 0 : tick_cnt + 1;
    assign us_tick = (tick_cnt == TDIV-1);

    assign scl_i = !scl_pull_o && !stuck && (hold_cnt == 0);
    assign sda_i = (rise_cnt >= k_rel);

    always_ff @(posedge clk) begin
        if (clr) begin
            rise_cnt <= 0; pulse_cnt <= 0; done_cnt <= 0; hold_cnt <= 0;
            hold_used <= 1'b0; width <= 0; min_w <= 1000000; max_w <= 0;
            scl_prev <= 1'b1; pull_prev <= 1'b0;
        end else begin
            scl_prev  <= scl_i;
            pull_prev <= scl_pull_o;
            if (scl_i && !scl_prev) rise_cnt <= rise_cnt + 1;
            if (scl_pull_o && !pull_prev) pulse_cnt <= pulse_cnt + 1;
            if (done_o) done_cnt <= done_cnt + 1;
            if (scl_pull_o) width <= width + 1;
            else if (pull_prev) begin
                if (width < min_w) min_w <= width;
                if (width > max_w) max_w <= width;
                width <= 0;
            end
            if (scl_pull_o && hold_len != 0 && !hold_used) begin
                hold_cnt <= hold_len; hold_used <= 1'b1;
            end else if (!scl_pull_o && hold_cnt != 0) hold_cnt <= hold_cnt - 1;
        end
    end

    i2c_bus_unstick #(
        .MAX_PULSES(MAXP), .LOW_US(LOW), .SETTLE_US(SETTLE),
        .STRETCH_US(STRETCH), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start_i(start_i),
        .scl_i(scl_i), .sda_i(sda_i), .scl_pull_o(scl_pull_o),
        .done_o(done_o), .ok_o(ok_o), .err_o(err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int rel, input bit stk, input int hold,
                            input bit busy_start, input bit exp_ok, input int exp_p,
                            input string req);
        int waited;
        @(negedge clk);
        k_rel = rel; stuck = stk; hold_len = hold; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R2 flags cleared"}, int'(ok_o) + int'(err_o), 0);
        // R2: still released through the first settle interval
        check({req, " R2 released"}, int'(scl_pull_o), 0);
        waited = 0;
        while (done_cnt == 0 && waited < 5000) begin
            @(negedge clk);
            waited++;
            if (busy_start && waited == 40) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        check({req, " run completes"}, int'(done_cnt != 0), 1);
        check({req, " ok flag"}, int'(ok_o), int'(exp_ok));
        check({req, " err flag"}, int'(err_o), int'(!exp_ok));
        check({req, " pulse count"}, pulse_cnt, exp_p);
        if (exp_p > 0) begin
            // R6: low phase width
            check({req, " R6 min width"}, int'(min_w >= (LOW-1)*TDIV + 1), 1);
            check({req, " R6 max width"}, int'(max_w <= LOW*TDIV + 2), 1);
        end
        repeat (10) @(negedge clk);
        // R8: single strobe, flag held
        check({req, " R8 one done"}, done_cnt, 1);
        check({req, " R8 ok held"}, int'(ok_o), int'(exp_ok));
        check({req, " R8 err held"}, int'(err_o), int'(!exp_ok));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pull", int'(scl_pull_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 flags", int'(ok_o) + int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", int'(scl_pull_o) + int'(done_o) + int'(ok_o) + int'(err_o), 0);

        // R4 / R5: sweep release point over and beyond the pulse limit
        for (int k = 0; k <= MAXP + 2; k++) begin
            if (k <= MAXP) run_case(k, 1'b0, 0, 1'b0, 1'b1, k, "R4 release sweep");
            else           run_case(k, 1'b0, 0, 1'b0, 1'b0, MAXP, "R5 never released");
        end
        run_case(NEVER, 1'b0, 0, 1'b0, 1'b0, MAXP, "R5 limit");
        // R3: SCL held low, with SDA high and with SDA low
        run_case(0, 1'b1, 0, 1'b0, 1'b0, 0, "R3 scl stuck sda high");
        run_case(NEVER, 1'b1, 0, 1'b0, 1'b0, 0, "R3 scl stuck sda low");
        // R7: tolerated stretch, then stretch beyond the limit
        run_case(2, 1'b0, 30, 1'b0, 1'b1, 2, "R7 short stretch");
        run_case(NEVER, 1'b0, 1000, 1'b0, 1'b0, 1, "R7 stretch timeout");
        // R9: request while busy ignored
        run_case(5, 1'b0, 0, 1'b1, 1'b1, 5, "R9 busy request");
        run_case(NEVER, 1'b0, 0, 1'b1, 1'b0, MAXP, "R9 busy request fail");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule